// File: doc/BRIEF.md
# Four-Channel Shadowed Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs. A simple single-cycle register bus sets them up. Each channel has three word registers: a period, a duty value and a control word. The control word holds a power-of-two count-rate divider and an output inversion bit.

A fixed-rate base tick input paces all counting. The control word divides this tick by 1, 2, 4 or 8 to form the channel's count step.

Settings never take effect halfway through a waveform. New duty and control values wait in staging registers. A write to the period register arms a commit, and the commit happens only when the running period reaches its end. If the channel is stopped, the commit happens on the next base tick instead. A period of zero stops the channel. It does so only after the period in flight has finished, and the output then stays low.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset every register reads zero, every channel is stopped and every output is low.
- R2: For channel n, the period word is at byte address 0x400+4n, the duty word at 0x420+4n and the control word at 0x440+4n. A read returns the last value written, keeping the low 16 bits of period and duty and only control bits [1:0] and 5, with all other bits zero. An access with address bits [1:0] nonzero, or to a slot with no channel, has no effect and reads zero.
- R3: A running channel counts from 0 to period-1 and then wraps. Its output is active while the count is below the duty value. Duty 0 gives a constant inactive level, and a duty of at least the period gives a constant active level.
- R4: Control bits [1:0] equal to k make each count step last 2^k base ticks. Clock cycles without a base tick never advance the count.
- R5: Control bit 5 set inverts the output of a running channel.
- R6: Writes to the duty or control word change no output until a period write has been committed.
- R7: After a period write to a running channel, the current period completes with the old settings. The staged period, duty and control then apply from the first count of the next period.
- R8: A committed period of zero lets the running period finish and then holds the output low, whatever the polarity, until a nonzero period is committed.
- R9: A period write to a stopped channel commits on the next base tick and starts counting at 0.
- R10: Each channel's registers and output are unaffected by accesses to other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle enable at the fixed base count rate |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
The embedded properties check several things on every cycle. The count never leaves the range set by the active period. Active settings stay frozen except at a period end. A stopped channel with nothing pending stays stopped, and counting restarts at zero. The prescaler stays within its divider mask and never moves without a base tick. The waveforms themselves can only be shown by the bench's scenarios: exact duty and period shapes, divider stretching, inversion, and the staging of new values across a period boundary. The same holds for the clean stop after a zero period, independence between channels and the register readback rules.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 16;
    localparam int DIV_W      = 2;
    localparam int INV_BIT    = 5;
    localparam int REGION_LSB = 5;
    localparam int PRE_W      = (1 << DIV_W) - 1;

    localparam logic [ADDR_W-1:0] PERIOD_BASE = 12'h400;
    localparam logic [ADDR_W-1:0] DUTY_BASE   = 12'h420;
    localparam logic [ADDR_W-1:0] CTRL_BASE   = 12'h440;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_PERIOD,
        RK_DUTY,
        RK_CTRL
    } reg_kind_e;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic [DIV_W-1:0] div;
        logic             inv;
    } chan_cfg_t;

    function automatic logic [PRE_W-1:0] div_mask(input logic [DIV_W-1:0] d);
        return PRE_W'((1 << d) - 1);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input logic [DIV_W-1:0] d,
                                                    input logic inv);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DIV_W-1:0] = d;
        w[INV_BIT] = inv;
        return w;
    endfunction

endpackage

// File: rtl/pwm_addr_decode.sv
module pwm_addr_decode
    import pwm_shadow_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [CH_W-1:0]   ch_idx
);
    localparam int SLOT_W = REGION_LSB - 2;

    logic [ADDR_W-REGION_LSB-1:0] page;
    logic [SLOT_W-1:0]            slot;
    logic                         aligned;
    logic                         slot_ok;

    assign page    = addr[ADDR_W-1:REGION_LSB];
    assign slot    = addr[REGION_LSB-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign slot_ok = (int'(slot) < NUM_CH);
    assign ch_idx  = slot[CH_W-1:0];

    always_comb begin
        kind = RK_NONE;
        if (aligned && slot_ok) begin
            if (page == PERIOD_BASE[ADDR_W-1:REGION_LSB])
                kind = RK_PERIOD;
            else if (page == DUTY_BASE[ADDR_W-1:REGION_LSB])
                kind = RK_DUTY;
            else if (page == CTRL_BASE[ADDR_W-1:REGION_LSB])
                kind = RK_CTRL;
        end
    end

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_shadow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             base_tick,
    input  logic [DIV_W-1:0] div,
    output logic             div_tick
);
    logic [PRE_W-1:0] presc;
    logic [PRE_W-1:0] mask;

    assign mask     = div_mask(div);
    assign div_tick = base_tick && (presc == mask);

    always_ff @(posedge clk) begin
        if (rst || hold)
            presc <= '0;
        else if (div_tick)
            presc <= '0;
        else if (base_tick)
            presc <= presc + 1'b1;
    end

    // R4: the prescaler never runs past the mask of the active divider
    p_presc_bound_r4: assert property (@(posedge clk) disable iff (rst)
        presc <= mask);

    // R4: no base tick, no prescaler movement
    p_presc_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !base_tick && !hold |=> $stable(presc));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_shadow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             base_tick,
    input  logic             wr_period,
    input  logic             wr_duty,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [DIV_W-1:0] wr_div,
    input  logic             wr_inv,
    output chan_cfg_t        staged,
    output logic             pwm_o
);
    chan_cfg_t        live;
    logic             pending;
    logic             running;
    logic [CNT_W-1:0] cnt;
    logic             div_tick;
    logic             period_end;
    logic             commit;

    pwm_prescale u_prescale (
        .clk       (clk),
        .rst       (rst),
        .hold      (!running),
        .base_tick (base_tick),
        .div       (live.div),
        .div_tick  (div_tick)
    );

    assign period_end = running && div_tick && (cnt == live.period - 1'b1);
    assign commit     = pending && ((!running && base_tick) || period_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged  <= '0;
            live    <= '0;
            pending <= 1'b0;
            running <= 1'b0;
            cnt     <= '0;
        end else begin
            if (wr_period) staged.period <= wr_val;
            if (wr_duty)   staged.duty   <= wr_val;
            if (wr_ctrl) begin
                staged.div <= wr_div;
                staged.inv <= wr_inv;
            end

            if (wr_period)
                pending <= 1'b1;
            else if (commit)
                pending <= 1'b0;

            if (commit) begin
                live    <= staged;
                running <= (staged.period != '0);
                cnt     <= '0;
            end else if (period_end) begin
                cnt <= '0;
            end else if (running && div_tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign pwm_o = running && ((cnt < live.duty) ^ live.inv);

    // R3: the count stays inside the active period
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        running |-> cnt < live.period);

    // R7: active settings move only at a period boundary
    p_live_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        running && !period_end |=> $stable(live));

    // R8: a stopped channel with nothing armed stays stopped
    p_stop_holds_r8: assert property (@(posedge clk) disable iff (rst)
        !running && !pending |=> !running && $stable(live));

    // R9: a fresh start counts from zero
    p_start_at_zero_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> cnt == '0);

    // R4: no base tick, no count step
    p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (rst)
        running && !base_tick |=> running && $stable(cnt));

endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
    import pwm_shadow_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_tick,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    reg_kind_e        kind;
    logic [CH_W-1:0]  ch_idx;
    logic             wr_en;
    chan_cfg_t        staged [NUM_CH];
    logic             unused_wdata;

    assign wr_en = bus_sel && bus_write;
    assign unused_wdata = ^{bus_wdata[DATA_W-1:CNT_W],
                            bus_wdata[CNT_W-1:INV_BIT+1],
                            bus_wdata[INV_BIT-1:DIV_W]};

    pwm_addr_decode #(.NUM_CH(NUM_CH)) u_decode (
        .addr   (bus_addr),
        .kind   (kind),
        .ch_idx (ch_idx)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic sel_me;
        assign sel_me = wr_en && (ch_idx == CH_W'(i));

        pwm_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .base_tick (base_tick),
            .wr_period (sel_me && kind == RK_PERIOD),
            .wr_duty   (sel_me && kind == RK_DUTY),
            .wr_ctrl   (sel_me && kind == RK_CTRL),
            .wr_val    (bus_wdata[CNT_W-1:0]),
            .wr_div    (bus_wdata[DIV_W-1:0]),
            .wr_inv    (bus_wdata[INV_BIT]),
            .staged    (staged[i]),
            .pwm_o     (pwm_out[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_write) begin
            case (kind)
                RK_PERIOD: bus_rdata = DATA_W'(staged[ch_idx].period);
                RK_DUTY:   bus_rdata = DATA_W'(staged[ch_idx].duty);
                RK_CTRL:   bus_rdata = ctrl_word(staged[ch_idx].div, staged[ch_idx].inv);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R2: an idle bus returns zero
    p_idle_bus_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> bus_rdata == '0);

endmodule

// File: tb/pwm_shadow_ctrl_bench.sv
module pwm_shadow_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_tick = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    ch;
        logic  lvl;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    pwm_shadow_ctrl u_pwm_shadow_ctrl (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [11:0] a_per(int ch);  return 12'h400 + 12'(4 * ch); endfunction
    function automatic logic [11:0] a_duty(int ch); return 12'h420 + 12'(4 * ch); endfunction
    function automatic logic [11:0] a_ctrl(int ch); return 12'h440 + 12'(4 * ch); endfunction

    // monitor: pops expected levels and compares them with the outputs
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() != 0) begin
                it = sb_q.pop_front();
                checks++;
                if (pwm_out[it.ch] !== it.lvl) begin
                    errors++;
                    $display("FAIL %s ch%0d: got %0b expected %0b", it.tag, it.ch,
                             pwm_out[it.ch], it.lvl);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        base_tick = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr 0x%03h: got 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
        end
        bus_sel = 1'b0;
    endtask

    // one character per cycle per channel: '0', '1' or '-' for no check
    task automatic expect_all(input string p0, input string p1, input string p2,
                              input string p3, input string tag);
        sb_item_t it;
        string    p;
        for (int i = 0; i < p0.len(); i++) begin
            for (int ch = 0; ch < 4; ch++) begin
                case (ch)
                    0: p = p0;
                    1: p = p1;
                    2: p = p2;
                    default: p = p3;
                endcase
                if (p[i] != "-") begin
                    it.ch = ch;
                    it.lvl = (p[i] == "1");
                    it.tag = tag;
                    sb_q.push_back(it);
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        do_reset();
        for (int ch = 0; ch < 4; ch++) begin
            bus_rd(a_per(ch),  32'h0, "R1 period");
            bus_rd(a_duty(ch), 32'h0, "R1 duty");
            bus_rd(a_ctrl(ch), 32'h0, "R1 ctrl");
        end
        expect_all("000", "000", "000", "000", "R1 outputs low");

        // R2: readback, field masking, unmapped and misaligned accesses
        bus_wr(a_duty(1), 32'h1234_5678);
        bus_wr(a_ctrl(3), 32'hFFFF_FFFF);
        bus_wr(12'h410, 32'h0000_0005);
        bus_wr(12'h401, 32'h0000_0009);
        bus_wr(a_per(2), 32'h0001_0000);
        bus_rd(a_duty(1), 32'h0000_5678, "R2 duty low half");
        bus_rd(a_ctrl(3), 32'h0000_0023, "R2 ctrl fields");
        bus_rd(12'h410, 32'h0, "R2 empty slot");
        bus_rd(a_per(0), 32'h0, "R2 stray write ignored");
        bus_rd(a_per(2), 32'h0, "R2 period low half");
        bus_rd(a_duty(0), 32'h0, "R10 other channel duty");
        // R6: staged duty/control with no period move no output
        expect_all("0000", "0000", "0000", "0000", "R6 staged only");

        // R3 and R9: basic waveform, start from stop
        do_reset();
        bus_wr(a_duty(0), 32'd3);
        bus_wr(a_per(0), 32'd5);
        expect_all("0111001110", "----------", "----------", "----------", "R3 R9 duty3 period5");

        // R3 corners and R10 independence
        do_reset();
        bus_wr(a_duty(1), 32'd0);
        bus_wr(a_duty(2), 32'd7);
        bus_wr(a_per(1), 32'd4);
        bus_wr(a_per(2), 32'd4);
        expect_all("000000000", "000000000", "011111111", "000000000", "R3 R10 duty 0 and over period");

        // R4: divide by 2
        do_reset();
        bus_wr(a_duty(0), 32'd2);
        bus_wr(a_ctrl(0), 32'd1);
        bus_wr(a_per(0), 32'd3);
        expect_all("011110011", "---------", "---------", "---------", "R4 divide by 2");

        // R4: divide by 8
        do_reset();
        bus_wr(a_duty(1), 32'd1);
        bus_wr(a_ctrl(1), 32'd3);
        bus_wr(a_per(1), 32'd2);
        expect_all("------------------", "011111111000000001", "------------------",
                   "------------------", "R4 divide by 8");

        // R4 and R9: commit and counting wait for the base tick
        do_reset();
        bus_wr(a_duty(2), 32'd1);
        bus_wr(a_per(2), 32'd2);
        base_tick = 1'b0;
        expect_all("----", "----", "0000", "----", "R9 start waits for tick");
        base_tick = 1'b1;
        expect_all("---", "---", "010", "---", "R9 start on tick");
        base_tick = 1'b0;
        expect_all("----", "----", "1111", "----", "R4 hold without tick");
        base_tick = 1'b1;
        expect_all("---", "---", "101", "---", "R4 resume on tick");

        // R5 then R8 with inversion: stop holds low
        do_reset();
        bus_wr(a_duty(3), 32'd1);
        bus_wr(a_ctrl(3), 32'h20);
        bus_wr(a_per(3), 32'd3);
        expect_all("--------", "--------", "--------", "00110110", "R5 inverted");
        bus_wr(a_per(3), 32'd0);
        expect_all("-------", "-------", "-------", "1000000", "R8 stop inverted low");

        // R6, R7 and R8 on one channel
        do_reset();
        bus_wr(a_duty(0), 32'd1);
        bus_wr(a_per(0), 32'd4);
        expect_all("0100010001", "----------", "----------", "----------", "R3 duty1 period4");
        bus_wr(a_duty(0), 32'd3);
        expect_all("001000", "------", "------", "------", "R6 duty staged");
        bus_wr(a_per(0), 32'd4);
        expect_all("00011101", "--------", "--------", "--------", "R7 commit at period end");
        bus_wr(a_per(0), 32'd0);
        expect_all("10000000", "--------", "--------", "--------", "R8 finish then stop");
        bus_rd(a_per(0), 32'h0, "R2 period zero readback");
        bus_rd(a_duty(0), 32'd3, "R2 duty readback");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule